// File: doc/BRIEF.md
# Oversampled I2C Register-Write Slave

This block is a write-only I2C target for a small control peripheral. A fast system clock oversamples SCL and SDA. Each line passes through a two-flop synchronizer and a majority-free agreement filter. The block then finds START and STOP conditions and the clock edges, and receives bytes MSB first. It acknowledges a byte by asserting an active-low pull-down enable. It never drives the line high.

A transfer begins with a device-address byte. Next comes a subaddress byte, which chooses one of nine 8-bit control registers and can turn on auto-increment. Any number of data bytes follow. Without auto-increment, every data byte overwrites the chosen register. With auto-increment, the bytes fill consecutive registers. Each accepted byte raises a one-cycle write strobe for its register, so downstream logic can act on the new value at once.

Top module: `i2c_regfile_slave`

## Requirements
- R1: While reset is asserted and directly after it, all register outputs read 0, no strobe bit is high and the pull-down enable is inactive (high).
- R2: A first byte of 1000100 followed by write flag 0 (byte 0x88) is acknowledged: the pull-down is active during the whole high phase of the ninth clock. Any other 7-bit address gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R3: An address byte with the read flag set (0x89) is not acknowledged, and no register is written in that transfer.
- R4: In the subaddress byte, bits 3..0 give the register index, bit 4 enables auto-increment, and bits 7..5 have no effect. The byte is acknowledged when the index is 0 to 8.
- R5: A subaddress index of 9 to 15 is not acknowledged, and no data byte of that transfer is written.
- R6: With auto-increment clear, every data byte is acknowledged and written to the same register.
- R7: With auto-increment set, the index advances by one after each written byte. A data byte that would go past register 8 is not acknowledged and not written.
- R8: Each accepted data byte gives exactly one single-cycle strobe on that register's bit of `wr_stb_o`, in the same cycle as the register output takes the new value. At most one strobe bit is high at a time.
- R9: A STOP releases SDA and returns the slave to idle. Clock pulses without a new START are not acknowledged.
- R10: A START that arrives in the middle of a byte discards the partial byte and restarts reception with the address byte.
- R11: A pulse shorter than FILT_LEN system clocks on SCL or SDA is ignored. It is counted neither as a clock edge nor as a START or STOP.
- R12: Bits are shifted in MSB first. Register i appears on `regs_o[8*i+7 : 8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pd_n_o | output | 1 | Active-low pull-down enable for SDA (0 = pull low) |
| regs_o | output | 72 | Nine 8-bit control registers, register i at bits 8*i+7..8*i |
| wr_stb_o | output | 9 | One-cycle write strobe per register |

## Verification
The acknowledge decision for a data byte and the write of that byte are made on the same filtered SCL falling edge. With auto-increment at register 8, that same edge also moves the pointer out of range. Transfers that start at index 7 or 8 with auto-increment set therefore check two things together: the last in-range byte must be both acknowledged and written, and the next byte must be refused and leave every register and strobe count unchanged. A negative-edge monitor also flags any change of a register output in a cycle where its strobe is low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W    = 8;
  localparam int SUB_IDX_W = 4;
  localparam int BITCNT_W  = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [1:0]          sync_q, sync_d;
  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic                filt_q, filt_d;

  always_comb begin
    sync_d = {sync_q[0], line_i};
    hist_d = {hist_q[FILT_LEN-2:0], sync_q[1]};
    filt_d = filt_q;
    if (&hist_q)       filt_d = 1'b1;
    else if (~|hist_q) filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise_o = ~scl_q &  scl_i;
    scl_fall_o =  scl_q & ~scl_i;
    start_o    =  scl_q &  scl_i &  sda_q & ~sda_i;
    stop_o     =  scl_q &  scl_i & ~sda_q &  sda_i;
  end

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         NREG     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 sda_i,
  output logic                 ack_o,
  output logic                 wr_en_o,
  output logic [SUB_IDX_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0]    wr_data_o
);

  localparam logic [SUB_IDX_W-1:0] LAST_IDX = SUB_IDX_W'(NREG - 1);
  localparam logic [BITCNT_W-1:0]  CNT_BYTE = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0]  CNT_ACK  = BITCNT_W'(BYTE_W + 1);

  phase_e                phase_q, phase_d;
  logic [BITCNT_W-1:0]   bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0]     shift_q, shift_d;
  logic [SUB_IDX_W-1:0]  ptr_q, ptr_d;
  logic                  ai_q, ai_d;
  logic                  ack_q, ack_d;
  logic                  wr_en_q, wr_en_d;
  logic [SUB_IDX_W-1:0]  wr_idx_q, wr_idx_d;
  logic [BYTE_W-1:0]     wr_data_q, wr_data_d;
  logic                  active;

  assign active = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);

  always_comb begin
    phase_d   = phase_q;
    bitcnt_d  = bitcnt_q;
    shift_d   = shift_q;
    ptr_d     = ptr_q;
    ai_d      = ai_q;
    ack_d     = ack_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;
    if (start_i) begin
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      ack_d    = 1'b0;
    end else if (stop_i) begin
      phase_d  = PH_IDLE;
      bitcnt_d = '0;
      ack_d    = 1'b0;
    end else if (active) begin
      if (scl_rise_i && bitcnt_q != CNT_ACK) begin
        if (bitcnt_q < CNT_BYTE) shift_d = {shift_q[BYTE_W-2:0], sda_i};
        bitcnt_d = bitcnt_q + 1'b1;
      end
      if (scl_fall_i && bitcnt_q == CNT_BYTE) begin
        unique case (phase_q)
          PH_ADDR: ack_d = (shift_q[7:1] == DEV_ADDR) && !shift_q[0];
          PH_SUB: begin
            ack_d = (shift_q[SUB_IDX_W-1:0] <= LAST_IDX);
            ptr_d = shift_q[SUB_IDX_W-1:0];
            ai_d  = shift_q[SUB_IDX_W];
          end
          PH_DATA: begin
            if (ptr_q <= LAST_IDX) begin
              ack_d     = 1'b1;
              wr_en_d   = 1'b1;
              wr_idx_d  = ptr_q;
              wr_data_d = shift_q;
              if (ai_q) ptr_d = ptr_q + 1'b1;
            end
          end
          default: ack_d = 1'b0;
        endcase
      end else if (scl_fall_i && bitcnt_q == CNT_ACK) begin
        bitcnt_d = '0;
        ack_d    = 1'b0;
        if (!ack_q)                phase_d = PH_SKIP;
        else if (phase_q == PH_ADDR) phase_d = PH_SUB;
        else                       phase_d = PH_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      bitcnt_q  <= '0;
      shift_q   <= '0;
      ptr_q     <= '0;
      ai_q      <= 1'b0;
      ack_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q   <= phase_d;
      bitcnt_q  <= bitcnt_d;
      shift_q   <= shift_d;
      ptr_q     <= ptr_d;
      ai_q      <= ai_d;
      ack_q     <= ack_d;
      wr_en_q   <= wr_en_d;
      wr_idx_q  <= wr_idx_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign ack_o     = ack_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;

  AST_ACK_IN_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (bitcnt_q == CNT_BYTE || bitcnt_q == CNT_ACK)); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !ack_q); // R9
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> wr_idx_q <= LAST_IDX); // R5
  AST_WRITE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> $past(phase_q) == PH_DATA); // R7
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> (!ack_q && !wr_en_q)); // R2

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int NREG = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [SUB_IDX_W-1:0]   wr_idx_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  output logic [NREG*BYTE_W-1:0] regs_o,
  output logic [NREG-1:0]        stb_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              hit;
    logic [BYTE_W-1:0] val_q, val_d;
    logic              stb_q;

    assign hit = wr_en_i && (wr_idx_i == SUB_IDX_W'(i));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        stb_q <= 1'b0;
      end else begin
        val_q <= val_d;
        stb_q <= hit;
      end
    end

    assign regs_o[i*BYTE_W +: BYTE_W] = val_q;
    assign stb_o[i]                   = stb_q;
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_o)); // R8
  AST_STB_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> $countones(stb_o) == 1); // R8

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         NREG     = 9,
  parameter int         FILT_LEN = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pd_n_o,
  output logic [NREG*BYTE_W-1:0] regs_o,
  output logic [NREG-1:0]        wr_stb_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0]    raw_lines, filt_lines;
  logic                 scl_rise, scl_fall, bus_start, bus_stop;
  logic                 ack;
  logic                 wr_en;
  logic [SUB_IDX_W-1:0] wr_idx;
  logic [BYTE_W-1:0]    wr_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  i2cs_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (filt_lines[0]),
    .sda_i      (filt_lines[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2cs_byte_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_i      (filt_lines[1]),
    .ack_o      (ack),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  i2cs_regbank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .regs_o    (regs_o),
    .stb_o     (wr_stb_o)
  );

  assign sda_pd_n_o = ~ack;

endmodule

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;
  localparam int NREG       = 9;
  localparam int NVEC       = 10;

  // vector: addr[41:34] sub[33:26] count[25:24] d0[23:16] d1[15:8] d2[7:0]
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h88, 8'h02, 2'd1, 8'hA5, 8'h00, 8'h00},
    {8'h88, 8'h13, 2'd3, 8'h11, 8'h22, 8'h33},
    {8'h88, 8'hE0, 2'd2, 8'h5A, 8'hC3, 8'h00},
    {8'h88, 8'h17, 2'd3, 8'h77, 8'h88, 8'h99},
    {8'h88, 8'h09, 2'd1, 8'h44, 8'h00, 8'h00},
    {8'h8A, 8'h01, 2'd1, 8'hFF, 8'h00, 8'h00},
    {8'h89, 8'h01, 2'd1, 8'hFF, 8'h00, 8'h00},
    {8'h88, 8'h0F, 2'd1, 8'h12, 8'h00, 8'h00},
    {8'h88, 8'h18, 2'd2, 8'h80, 8'h01, 8'h00},
    {8'h88, 8'h01, 2'd3, 8'h01, 8'h02, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_bus;
  logic sda_pd_n;
  logic [NREG*8-1:0] regs;
  logic [NREG-1:0]   stb;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & sda_pd_n;

  i2c_regfile_slave dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pd_n_o (sda_pd_n),
    .regs_o     (regs),
    .wr_stb_o   (stb)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [7:0] exp_reg [NREG];
  int         exp_cnt [NREG];
  int         stb_cnt [NREG];
  int         stb_err = 0;
  logic [7:0] prev_reg [NREG];
  logic [NREG-1:0] prev_stb;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if ($countones(stb) > 1) stb_err++;
      for (int i = 0; i < NREG; i++) begin
        if (stb[i]) stb_cnt[i]++;
        if (stb[i] && prev_stb[i]) stb_err++;
        if (regs[i*8 +: 8] != prev_reg[i] && !stb[i]) stb_err++;
      end
    end
    for (int i = 0; i < NREG; i++) prev_reg[i] = regs[i*8 +: 8];
    prev_stb = stb;
  end

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 180000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<180000", cycles);
      report();
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    wait_clk(5); sda_m = 1'b1;
    wait_clk(HALF); scl_m = 1'b1;
    wait_clk(HALF); sda_m = 1'b0;
    wait_clk(HALF); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    wait_clk(5); sda_m = 1'b0;
    wait_clk(HALF); scl_m = 1'b1;
    wait_clk(HALF); sda_m = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    wait_clk(5); sda_m = b;
    wait_clk(HALF-5); scl_m = 1'b1;
    wait_clk(HALF); scl_m = 1'b0;
  endtask

  task automatic ack_clock(output logic acked);
    logic low_a, low_b;
    wait_clk(5); sda_m = 1'b1;
    wait_clk(HALF-5); scl_m = 1'b1;
    wait_clk(2); low_a = (sda_bus == 1'b0);
    wait_clk(HALF-4); low_b = (sda_bus == 1'b0);
    wait_clk(2); scl_m = 1'b0;
    acked = low_a && low_b;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    ack_clock(acked);
  endtask

  // byte with a 1-clock SCL pulse while SCL is low and a 1-clock SDA dip while SCL is high
  task automatic send_byte_glitch(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(5); sda_m = b[i];
      wait_clk(HALF-5); scl_m = 1'b1;
      wait_clk(HALF/2);
      if (i == 4) begin sda_m = 1'b0; wait_clk(1); sda_m = b[i]; end
      else wait_clk(1);
      wait_clk(HALF/2 - 1); scl_m = 1'b0;
      if (i == 5) begin wait_clk(8); scl_m = 1'b1; wait_clk(1); scl_m = 1'b0; end
    end
    ack_clock(acked);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) begin
      check({req, " reg value"}, 32'(regs[i*8 +: 8]), 32'(exp_reg[i]));
      check("R8 strobe count", stb_cnt[i], exp_cnt[i]);
    end
  endtask

  task automatic run_vec(input logic [41:0] v);
    logic [7:0] addr, sub;
    logic [7:0] dat [3];
    int         n;
    logic       acked, a_ok, s_ok, d_ok, ai;
    logic [4:0] ptr;
    addr = v[41:34]; sub = v[33:26]; n = int'(v[25:24]);
    dat[0] = v[23:16]; dat[1] = v[15:8]; dat[2] = v[7:0];
    a_ok = (addr == 8'h88);
    s_ok = a_ok && (sub[3:0] <= 4'd8);
    ptr  = {1'b0, sub[3:0]};
    ai   = sub[4];
    bus_start();
    send_byte(addr, acked);
    check(addr[0] ? "R3 read flag ack" : "R2 address ack", 32'(acked), 32'(a_ok));
    send_byte(sub, acked);
    check((sub[3:0] > 4'd8) ? "R5 subaddress ack" : "R4 subaddress ack",
          32'(acked), 32'(s_ok));
    for (int k = 0; k < n; k++) begin
      d_ok = s_ok && (ptr <= 5'd8);
      send_byte(dat[k], acked);
      check(ai ? "R7 data ack" : "R6 data ack", 32'(acked), 32'(d_ok));
      if (d_ok) begin
        exp_reg[ptr[3:0]] = dat[k];
        exp_cnt[ptr[3:0]]++;
        if (ai) ptr = ptr + 5'd1;
      end
    end
    bus_stop();
    wait_clk(10);
    check_regs(ai ? "R7 R12" : "R6 R12");
  endtask

  initial begin
    logic acked;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) begin exp_reg[i] = 8'h00; exp_cnt[i] = 0; stb_cnt[i] = 0; end
    wait_clk(5);
    check("R1 regs in reset", 32'(regs == '0), 32'd1);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 regs after reset", 32'(regs == '0), 32'd1);
    check("R1 strobes after reset", 32'(stb), 32'd0);
    check("R1 pull-down released", 32'(sda_pd_n), 32'd1);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

    // R9: clocking a byte after STOP without a START is not acknowledged
    send_byte(8'h88, acked);
    check("R9 no ack after stop", 32'(acked), 32'd0);
    send_byte(8'h00, acked);
    check("R9 no ack after stop", 32'(acked), 32'd0);
    wait_clk(10);
    check_regs("R9");

    // R10: repeated START in the middle of a data byte
    bus_start();
    send_byte(8'h88, acked);
    check("R10 address ack", 32'(acked), 32'd1);
    send_byte(8'h02, acked);
    check("R10 subaddress ack", 32'(acked), 32'd1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'h88, acked);
    check("R10 address after restart", 32'(acked), 32'd1);
    send_byte(8'h05, acked);
    check("R10 subaddress after restart", 32'(acked), 32'd1);
    send_byte(8'h3C, acked);
    check("R10 data after restart", 32'(acked), 32'd1);
    exp_reg[5] = 8'h3C; exp_cnt[5]++;
    bus_stop();
    wait_clk(10);
    check_regs("R10");

    // R11: short glitches on both lines are ignored
    bus_start();
    send_byte(8'h88, acked);
    send_byte(8'h06, acked);
    send_byte_glitch(8'h5A, acked);
    check("R11 data ack with glitches", 32'(acked), 32'd1);
    exp_reg[6] = 8'h5A; exp_cnt[6]++;
    bus_stop();
    wait_clk(10);
    check_regs("R11");

    check("R8 strobe shape and alignment", stb_err, 0);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    wait_clk(3);
    check("R1 regs cleared by reset", 32'(regs == '0), 32'd1);
    check("R1 strobes cleared by reset", 32'(stb), 32'd0);
    check("R1 pull-down released in reset", 32'(sda_pd_n), 32'd1);
    rst_n = 1'b1;
    wait_clk(5);

    report();
    $finish;
  end

endmodule